// File: doc/BRIEF.md
# Burst Splitter with Write Response Coalescing

This block sits on the address path between a wide memory-mapped port and a narrower one. It takes each read or write address request from the wide side. When the transfer size is wider than the narrow data path, it multiplies the burst length by the width ratio and narrows the transfer size. If the scaled length is longer than the protocol's beat limit, it cuts the request into several narrow bursts, each within that limit. The data path that serialises the write data and merges the read data is a separate block. It is steered by a command record that comes out with every narrow request: the direction, the number of narrow beats per wide beat, and whether this burst is the last piece of its wide request.

On the write side, the block queues one expected response count per accepted write. It then folds that many narrow write responses into a single response on the wide side, which carries the most severe code it has seen. A request whose transfer size fits the narrow port goes through as it is. The protocol variant is a parameter: the beat limit is 16 for the older variant and 256 for the newer one.

Top module: `burst_splitter`

## Requirements
- R1: When the transfer size (log2 bytes) is at most the narrow width, exactly one narrow request is issued, with the same address, length, size and lock as the wide request.
- R2: When the transfer size exceeds the narrow width, the narrow size equals the narrow width. The narrow bursts of the request together carry (len+1) << (size - narrowLog) beats.
- R3: Every narrow burst except the last of its request has length field LIMIT-1 (LIMIT = 16 in AXI3 mode, 256 otherwise). The last burst carries the remaining beats, so the number of bursts is the total divided by LIMIT, rounded up.
- R4: Each narrow burst after the first starts at the previous burst's address plus LIMIT << narrowLog bytes.
- R5: If a request is split into more than one burst, every narrow burst has lock = 0. An unsplit request keeps its lock bit.
- R6: The cache attribute bits go through unchanged on every narrow burst, and they have no effect on splitting.
- R7: A write produces exactly one wide response. It is raised only together with the narrow response that completes the write's burst count. Earlier narrow responses are accepted without waiting for the wide ready.
- R8: The combined wide response is the most severe of the collected codes. Severity ranks, from highest: DECERR (2'b11), SLVERR (2'b10), OKAY (2'b00), EXOKAY (2'b01).
- R9: For a split write, a combined EXOKAY is reported as OKAY. For a single-burst write, the narrow code passes through unchanged, including EXOKAY.
- R10: Each narrow request carries a command record. The direction bit (1 = write) follows the wide request. The ratio field is size - narrowLog when downsizing and 0 otherwise. The last flag is 1 only on the final burst of the request.
- R11: The wide ready is low while narrow bursts of the current request are pending. A narrow request held without ready keeps its address, length and lock stable.
- R12: Reads queue no response count, so a narrow response arriving with no write pending is neither accepted nor forwarded. When DEPTH writes are awaiting responses, the wide ready stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| aValid | input | 1 | Wide request valid |
| aReady | output | 1 | Wide request ready |
| aAddr | input | ADDR_W | Wide request byte address |
| aLen | input | LEN_W | Wide burst length minus one |
| aSize | input | 3 | Transfer size, log2 bytes |
| aLock | input | 1 | Exclusive access flag |
| aCache | input | 4 | Cache attribute bits |
| aWrite | input | 1 | 1 = write request, 0 = read request |
| nAValid | output | 1 | Narrow request valid |
| nAReady | input | 1 | Narrow request ready |
| nAAddr | output | ADDR_W | Narrow burst address |
| nALen | output | LEN_W | Narrow burst length minus one |
| nASize | output | 3 | Narrow transfer size |
| nALock | output | 1 | Narrow lock flag |
| nACache | output | 4 | Narrow cache bits |
| nAWrite | output | 1 | Command record: direction |
| nCmdRatioLog | output | 3 | Command record: log2 narrow beats per wide beat |
| nCmdLast | output | 1 | Command record: final burst of the request |
| nBValid | input | 1 | Narrow write response valid |
| nBReady | output | 1 | Narrow write response ready |
| nBResp | input | 2 | Narrow write response code |
| bValid | output | 1 | Wide write response valid |
| bReady | input | 1 | Wide write response ready |
| bResp | output | 2 | Combined wide write response code |

## Verification
The bench builds the block with a 128-bit wide side, a 32-bit narrow side, the 16-beat limit and a four-entry response queue. With these values a request is split into at most four narrow bursts. That makes it practical to sweep every transfer size from 1 to 16 bytes, every length from 1 to 16 beats, both lock values and both directions. The sweep therefore covers passthrough, scaling without a split, and splits ending in both full and partial last bursts. Each write's response codes vary with the transaction index, so single-burst EXOKAY, demoted EXOKAY and every severity pairing occur. A separate run fills the queue to its depth.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;

  typedef struct packed {
    logic load;     // wide request accepted this cycle
    logic advance;  // narrow burst accepted this cycle
  } strobe_t;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_EXOKAY = 2'b01;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
  localparam logic [1:0] RESP_DECERR = 2'b11;

  function automatic logic [1:0] severity(input logic [1:0] code);
    case (code)
      RESP_DECERR: severity = 2'd3;
      RESP_SLVERR: severity = 2'd2;
      RESP_OKAY:   severity = 2'd1;
      default:     severity = 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] worseResp(input logic [1:0] a, input logic [1:0] b);
    worseResp = (severity(b) > severity(a)) ? b : a;
  endfunction

endpackage

// File: rtl/bsplit_ctrl.sv
module bsplit_ctrl
  import bsplit_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    aValid,
  input  logic    qFull,
  input  logic    nAReady,
  input  logic    lastBurst,
  output logic    aReady,
  output logic    nAValid,
  output strobe_t strobe
);

  logic busyQ;

  assign aReady         = !busyQ && !qFull;
  assign nAValid        = busyQ;
  assign strobe.load    = aValid && aReady;
  assign strobe.advance = busyQ && nAReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
    end else if (strobe.load) begin
      busyQ <= 1'b1;
    end else if (strobe.advance && lastBurst) begin
      busyQ <= 1'b0;
    end
  end

  a_r11_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    nAValid |-> !aReady);

endmodule

// File: rtl/bsplit_datapath.sv
module bsplit_datapath
  import bsplit_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 8,
  parameter int NARROW_LOG = 2,
  parameter int LIMIT_LOG  = 8,
  parameter int TOT_W      = 12,
  parameter int CNT_W      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [LEN_W-1:0]  aLen,
  input  logic [2:0]        aSize,
  input  logic              aLock,
  input  logic [3:0]        aCache,
  input  logic              aWrite,
  output logic [ADDR_W-1:0] nAAddr,
  output logic [LEN_W-1:0]  nALen,
  output logic [2:0]        nASize,
  output logic              nALock,
  output logic [3:0]        nACache,
  output logic              nAWrite,
  output logic [2:0]        nCmdRatioLog,
  output logic              lastBurst,
  output logic [CNT_W-1:0]  burstCount
);

  localparam logic [TOT_W-1:0]  LIMIT   = TOT_W'(1) << LIMIT_LOG;
  localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(1) << (LIMIT_LOG + NARROW_LOG);
  localparam logic [2:0]        NARROW3 = 3'(NARROW_LOG);

  logic              downIn;
  logic [2:0]        ratioIn;
  logic [TOT_W-1:0]  totalIn;
  logic              splitIn;

  logic [ADDR_W-1:0] addrQ;
  logic [TOT_W-1:0]  remQ;
  logic [2:0]        sizeQ;
  logic [2:0]        ratioQ;
  logic              lockQ;
  logic [3:0]        cacheQ;
  logic              writeQ;

  assign downIn     = aSize > NARROW3;
  assign ratioIn    = downIn ? (aSize - NARROW3) : 3'd0;
  assign totalIn    = (TOT_W'(aLen) + TOT_W'(1)) << ratioIn;
  assign splitIn    = totalIn > LIMIT;
  assign burstCount = CNT_W'((totalIn + LIMIT - TOT_W'(1)) >> LIMIT_LOG);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      remQ   <= '0;
      sizeQ  <= '0;
      ratioQ <= '0;
      lockQ  <= 1'b0;
      cacheQ <= '0;
      writeQ <= 1'b0;
    end else if (strobe.load) begin
      addrQ  <= aAddr;
      remQ   <= totalIn;
      sizeQ  <= downIn ? NARROW3 : aSize;
      ratioQ <= ratioIn;
      lockQ  <= aLock && !splitIn;
      cacheQ <= aCache;
      writeQ <= aWrite;
    end else if (strobe.advance) begin
      addrQ <= addrQ + STEP;
      remQ  <= remQ - LIMIT;
    end
  end

  assign lastBurst    = remQ <= LIMIT;
  assign nALen        = lastBurst ? LEN_W'(remQ - TOT_W'(1)) : LEN_W'(LIMIT - TOT_W'(1));
  assign nAAddr       = addrQ;
  assign nASize       = sizeQ;
  assign nALock       = lockQ;
  assign nACache      = cacheQ;
  assign nAWrite      = writeQ;
  assign nCmdRatioLog = ratioQ;

endmodule

// File: rtl/bsplit_coalesce.sv
module bsplit_coalesce
  import bsplit_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic [CNT_W-1:0] pushCount,
  output logic             qFull,
  input  logic             nBValid,
  output logic             nBReady,
  input  logic [1:0]       nBResp,
  output logic             bValid,
  input  logic             bReady,
  output logic [1:0]       bResp
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cntMem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [LVL_W-1:0] level;
  logic [CNT_W-1:0] seenQ;
  logic [1:0]       accQ;

  logic             empty, isLast, take, pop;
  logic [CNT_W-1:0] head;
  logic [1:0]       combined;

  assign empty    = level == '0;
  assign qFull    = level == LVL_W'(DEPTH);
  assign head     = cntMem[rdPtr];
  assign isLast   = (seenQ + CNT_W'(1)) == head;
  assign combined = (seenQ == '0) ? nBResp : worseResp(accQ, nBResp);
  assign bResp    = (head > CNT_W'(1) && combined == RESP_EXOKAY) ? RESP_OKAY : combined;
  assign nBReady  = !empty && (!isLast || bReady);
  assign bValid   = nBValid && !empty && isLast;
  assign take     = nBValid && nBReady;
  assign pop      = bValid && bReady;

  always_ff @(posedge clk) begin
    if (pushValid) cntMem[wrPtr] <= pushCount;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
      seenQ <= '0;
      accQ  <= RESP_OKAY;
    end else begin
      if (pushValid) wrPtr <= wrPtr + PTR_W'(1);
      if (pop)       rdPtr <= rdPtr + PTR_W'(1);
      level <= level + LVL_W'(pushValid) - LVL_W'(pop);
      if (pop)       seenQ <= '0;
      else if (take) seenQ <= seenQ + CNT_W'(1);
      if (take)      accQ <= combined;
    end
  end

  a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> !qFull);

  a_r7_group_restart: assert property (@(posedge clk) disable iff (!rstN)
    pop |=> seenQ == '0);

endmodule

// File: rtl/burst_splitter.sv
module burst_splitter
  import bsplit_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WIDE_LOG   = 5,
  parameter int NARROW_LOG = 2,
  parameter bit AXI3_MODE  = 1'b0,
  parameter int DEPTH      = 4,
  localparam int LIMIT_LOG = AXI3_MODE ? 4 : 8,
  localparam int LEN_W     = LIMIT_LOG,
  localparam int TOT_W     = LEN_W + 1 + (WIDE_LOG - NARROW_LOG),
  localparam int CNT_W     = TOT_W - LIMIT_LOG + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aValid,
  output logic              aReady,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [LEN_W-1:0]  aLen,
  input  logic [2:0]        aSize,
  input  logic              aLock,
  input  logic [3:0]        aCache,
  input  logic              aWrite,
  output logic              nAValid,
  input  logic              nAReady,
  output logic [ADDR_W-1:0] nAAddr,
  output logic [LEN_W-1:0]  nALen,
  output logic [2:0]        nASize,
  output logic              nALock,
  output logic [3:0]        nACache,
  output logic              nAWrite,
  output logic [2:0]        nCmdRatioLog,
  output logic              nCmdLast,
  input  logic              nBValid,
  output logic              nBReady,
  input  logic [1:0]        nBResp,
  output logic              bValid,
  input  logic              bReady,
  output logic [1:0]        bResp
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << (LIMIT_LOG + NARROW_LOG);

  strobe_t          strobe;
  logic             lastBurst;
  logic             qFull;
  logic [CNT_W-1:0] burstCount;

  bsplit_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .aValid(aValid), .qFull(qFull), .nAReady(nAReady),
    .lastBurst(lastBurst), .aReady(aReady), .nAValid(nAValid), .strobe(strobe)
  );

  bsplit_datapath #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .NARROW_LOG(NARROW_LOG),
    .LIMIT_LOG(LIMIT_LOG), .TOT_W(TOT_W), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .aAddr(aAddr), .aLen(aLen), .aSize(aSize), .aLock(aLock), .aCache(aCache), .aWrite(aWrite),
    .nAAddr(nAAddr), .nALen(nALen), .nASize(nASize), .nALock(nALock), .nACache(nACache),
    .nAWrite(nAWrite), .nCmdRatioLog(nCmdRatioLog), .lastBurst(lastBurst), .burstCount(burstCount)
  );

  bsplit_coalesce #(.CNT_W(CNT_W), .DEPTH(DEPTH)) coal_i (
    .clk(clk), .rstN(rstN), .pushValid(strobe.load && aWrite), .pushCount(burstCount),
    .qFull(qFull), .nBValid(nBValid), .nBReady(nBReady), .nBResp(nBResp),
    .bValid(bValid), .bReady(bReady), .bResp(bResp)
  );

  assign nCmdLast = lastBurst;

  a_r11_hold_stall: assert property (@(posedge clk) disable iff (!rstN)
    nAValid && !nAReady |=> nAValid && $stable(nAAddr) && $stable(nALen) && $stable(nALock));

  a_r3_full_burst: assert property (@(posedge clk) disable iff (!rstN)
    nAValid && !nCmdLast |-> nALen == LEN_W'((1 << LIMIT_LOG) - 1));

  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    nAValid && nAReady && !nCmdLast |=> nAValid && nAAddr == $past(nAAddr) + STEP);

  a_r5_split_unlocked: assert property (@(posedge clk) disable iff (!rstN)
    nAValid && !nCmdLast |-> !nALock);

endmodule

// File: tb/burst_splitter_tb_top.sv
module burst_splitter_tb_top;

  localparam int ADDR_W = 32;
  localparam int LEN_W  = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              aValid = 1'b0, aReady;
  logic [ADDR_W-1:0] aAddr = '0;
  logic [LEN_W-1:0]  aLen = '0;
  logic [2:0]        aSize = '0;
  logic              aLock = 1'b0;
  logic [3:0]        aCache = '0;
  logic              aWrite = 1'b0;
  logic              nAValid, nAReady = 1'b0;
  logic [ADDR_W-1:0] nAAddr;
  logic [LEN_W-1:0]  nALen;
  logic [2:0]        nASize;
  logic              nALock;
  logic [3:0]        nACache;
  logic              nAWrite;
  logic [2:0]        nCmdRatioLog;
  logic              nCmdLast;
  logic              nBValid = 1'b0, nBReady;
  logic [1:0]        nBResp = '0;
  logic              bValid, bReady = 1'b0;
  logic [1:0]        bResp;

  int nChecks = 0;
  int nErrors = 0;

  always #4 clk = ~clk;

  burst_splitter #(
    .ADDR_W(ADDR_W), .WIDE_LOG(4), .NARROW_LOG(2), .AXI3_MODE(1'b1), .DEPTH(4)
  ) dut_i (
    .clk(clk), .rstN(rstN), .aValid(aValid), .aReady(aReady), .aAddr(aAddr), .aLen(aLen),
    .aSize(aSize), .aLock(aLock), .aCache(aCache), .aWrite(aWrite),
    .nAValid(nAValid), .nAReady(nAReady), .nAAddr(nAAddr), .nALen(nALen), .nASize(nASize),
    .nALock(nALock), .nACache(nACache), .nAWrite(nAWrite), .nCmdRatioLog(nCmdRatioLog),
    .nCmdLast(nCmdLast), .nBValid(nBValid), .nBReady(nBReady), .nBResp(nBResp),
    .bValid(bValid), .bReady(bReady), .bResp(bResp)
  );

  task automatic check(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    finishRun();
  end

  // Expected wide code from a list of narrow codes, by scanning for each class.
  function automatic logic [1:0] expectResp(input logic [1:0] codes [4], input int n);
    bit anyDec = 0, anySlv = 0;
    for (int i = 0; i < n; i++) begin
      if (codes[i] == 2'b11) anyDec = 1;
      if (codes[i] == 2'b10) anySlv = 1;
    end
    if (anyDec) return 2'b11;
    if (anySlv) return 2'b10;
    if (n == 1) return codes[0];
    return 2'b00;
  endfunction

  task automatic sendRequest(input bit wr, input int sz, input int ln, input bit lk,
                             input logic [ADDR_W-1:0] addr, input logic [3:0] cache);
    @(negedge clk);
    aValid = 1'b1; aWrite = wr; aSize = 3'(sz); aLen = LEN_W'(ln);
    aLock = lk; aAddr = addr; aCache = cache;
    while (!aReady) @(negedge clk);
    @(negedge clk);
    aValid = 1'b0;
  endtask

  task automatic runTxn(input bit wr, input int sz, input int ln, input bit lk, input int idx);
    int ratio, total, n, lastLen;
    logic [ADDR_W-1:0] addr;
    logic [3:0] cache;
    logic [1:0] codes [4];
    ratio   = (sz > 2) ? sz - 2 : 0;
    total   = (ln + 1) << ratio;
    n       = (total + 15) / 16;
    lastLen = total - 16 * (n - 1) - 1;
    addr    = ADDR_W'(idx) * 32'h1000 + (ADDR_W'(idx % 4) << sz);
    cache   = 4'(idx);
    sendRequest(wr, sz, ln, lk, addr, cache);
    for (int k = 0; k < n; k++) begin
      check("R11 narrow valid", nAValid, 1);
      check("R1/R4 narrow addr", nAAddr, addr + ADDR_W'(k * 64));
      check("R2/R3 narrow len", nALen, (k < n - 1) ? 15 : lastLen);
      check("R2 narrow size", nASize, (sz > 2) ? 2 : sz);
      check("R5 narrow lock", nALock, (lk && n == 1) ? 1 : 0);
      check("R6 narrow cache", nACache, cache);
      check("R10 cmd direction", nAWrite, wr);
      check("R10 cmd ratio", nCmdRatioLog, ratio);
      check("R10 cmd last", nCmdLast, (k == n - 1) ? 1 : 0);
      check("R11 wide ready low while busy", aReady, 0);
      if (k == 0 && idx % 3 == 0) begin
        @(negedge clk);
        check("R11 stall valid", nAValid, 1);
        check("R11 stall addr", nAAddr, addr);
        check("R11 stall len", nALen, (n > 1) ? 15 : lastLen);
      end
      nAReady = 1'b1;
      @(negedge clk);
      nAReady = 1'b0;
    end
    check("R3 burst count exact", nAValid, 0);
    if (wr) begin
      for (int k = 0; k < n; k++) codes[k] = 2'((idx + k * 3 + (k >> 1)) & 3);
      for (int k = 0; k < n; k++) begin
        nBValid = 1'b1; nBResp = codes[k]; bReady = (k == n - 1);
        #1;
        check("R7 narrow ready", nBReady, 1);
        check("R7 wide valid only on final", bValid, (k == n - 1) ? 1 : 0);
        if (k == n - 1) check((n > 1) ? "R8/R9 combined code" : "R9 single code", bResp, expectResp(codes, n));
        @(negedge clk);
        nBValid = 1'b0; bReady = 1'b0;
      end
      #1;
      check("R7 no extra wide response", bValid, 0);
    end else begin
      nBValid = 1'b1; nBResp = 2'b00; bReady = 1'b1;
      #1;
      check("R12 read queues no response", nBReady, 0);
      check("R12 read forwards no response", bValid, 0);
      @(negedge clk);
      nBValid = 1'b0; bReady = 1'b0;
    end
  endtask

  initial begin
    int idx = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 reset ready", aReady, 1);
    check("R11 reset narrow idle", nAValid, 0);
    check("R7 reset no response", bValid, 0);

    for (int wr = 0; wr < 2; wr++)
      for (int sz = 0; sz <= 4; sz++)
        for (int ln = 0; ln < 16; ln++)
          for (int lk = 0; lk < 2; lk++) begin
            runTxn(wr[0], sz, ln, lk[0], idx);
            idx++;
          end

    // Queue depth: four writes outstanding block a fifth request.
    for (int t = 0; t < 4; t++) begin
      sendRequest(1'b1, 0, t, 1'b0, ADDR_W'(t) << 8, 4'h0);
      nAReady = 1'b1;
      @(negedge clk);
      nAReady = 1'b0;
    end
    aValid = 1'b1; aWrite = 1'b1;
    @(negedge clk);
    check("R12 full queue blocks request", aReady, 0);
    aValid = 1'b0;
    for (int t = 0; t < 4; t++) begin
      nBValid = 1'b1; nBResp = 2'(t); bReady = 1'b1;
      #1;
      check("R7 queued write response", bValid, 1);
      check("R9 queued single code", bResp, t);
      @(negedge clk);
      nBValid = 1'b0; bReady = 1'b0;
    end
    check("R12 queue drained ready", aReady, 1);
    finishRun();
  end

endmodule